// File: doc/BRIEF.md
# Channel-Tagged Stream Sorter

This block sits at the receiving end of a 16-bit parallel link that carries acquisition samples from 24 channels. Each sample travels as a 32-bit word split into two 16-bit halves. The tag half goes first and names the channel. The sample half follows. The block pairs the halves back into words and checks each tag. For every good word it emits the sample on a valid/data/channel output, with the channel given as a zero-based index.

The channel comes from the tag in each word, not from the word's place in a batch. A lost or damaged halfword therefore costs at most that one word. A halfword whose value is not a legal channel number is rejected as a tag. The receiver reports a one-cycle error pulse and treats the next halfword as a fresh tag candidate, so the stream re-aligns by itself.

The block also counts errors and accepted samples:
- one 16-bit counter of rejected tags;
- one 16-bit counter of accepted samples for each channel, read back through a channel-select input.

Top module: `tagsort_rx`

## Requirements
- R1: A synchronous active-high reset sets the halfword phase to "expect tag" and clears every per-channel counter and the error counter. It also drives `smp_valid` and `tag_err` low. A word half-received when reset is applied is discarded.
- R2: After reset, and after each completed word, the next strobed halfword is taken as a tag and the strobed halfword after it as the sample. One cycle after the sample strobe, `smp_valid` is high for exactly one cycle, `smp_data` equals the sample halfword and `smp_chan` equals tag minus 1.
- R3: A tag is valid only if its value is 0x0001 to 0x0018 inclusive. Channel 1 is tag 0x0001, so the word 0x0001DE33 delivers sample 0xDE33 on index 0. Tag 0x0000 and any value above 0x0018 are invalid. An invalid tag raises `tag_err` for one cycle, one cycle after its strobe, and produces no sample. The next strobed halfword is treated as a tag candidate.
- R4: `err_count` rises by exactly one on the cycle after each `tag_err` pulse and holds otherwise.
- R5: Each accepted sample adds one to the counter of its channel in the cycle after `smp_valid`. `chan_count` combinationally shows the counter picked by `sel_chan`, a zero-based index. A `sel_chan` of 24 or more reads zero.
- R6: Cycles with `hw_valid` low change neither the phase nor any output, so idle gaps between the two halves of a word are allowed.
- R7: A stream that has lost a halfword re-aligns. Each misplaced sample half that fails the tag check costs one error, and the next valid tag and its sample are sorted correctly.
- R8: `smp_valid` and `tag_err` are never high in the same cycle, and `smp_valid` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_valid | input | 1 | Strobe marking a valid halfword on `hw_data` |
| hw_data | input | 16 | Incoming halfword, tag half first |
| sel_chan | input | 5 | Zero-based channel whose sample counter is shown |
| smp_valid | output | 1 | One-cycle pulse for an accepted sample |
| smp_data | output | 16 | Accepted sample value |
| smp_chan | output | 5 | Zero-based channel index of the sample |
| tag_err | output | 1 | One-cycle pulse for a rejected tag |
| err_count | output | 16 | Number of rejected tags, wrapping |
| chan_count | output | 16 | Accepted-sample count of the selected channel, wrapping |

## Verification
Several properties are checked on every clock cycle:
- the output pulses are exclusive and last a single cycle;
- a delivered channel index is always in range;
- the phase holds while no strobe arrives;
- an error pulse only occurs while the framer is waiting for a tag;
- the error counter and the selected channel counter move only in step with their pulses.

Other behaviours can only be shown by the bench's scenarios, because they depend on stimulus sequences:
- the exact sample and index delivered for a given tag;
- the range boundaries at tags 0x0000, 0x0018 and 0x0019;
- re-alignment after a dropped halfword;
- a reset that arrives halfway through a word;
- the per-channel totals read back after a mixed stream.

// File: rtl/tagsort_pkg.sv
package tagsort_pkg;

    localparam int CHAN_COUNT = 24;
    localparam int HALF_W     = 16;
    localparam int CNT_W      = 16;
    localparam int IDX_W      = $clog2(CHAN_COUNT);

    typedef enum logic {
        PH_TAG    = 1'b0,
        PH_SAMPLE = 1'b1
    } phase_e;

    typedef struct packed {
        logic              valid;
        logic [HALF_W-1:0] data;
        logic [IDX_W-1:0]  chan;
    } sample_t;

    // A tag is legal when it names channel 1..CHAN_COUNT.
    function automatic logic tag_ok(input logic [HALF_W-1:0] t);
        return (t >= HALF_W'(1)) && (t <= HALF_W'(CHAN_COUNT));
    endfunction

    function automatic logic [IDX_W-1:0] tag_to_idx(input logic [HALF_W-1:0] t);
        logic [HALF_W-1:0] z;
        z = t - HALF_W'(1);
        return z[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/tagsort_framer.sv
module tagsort_framer
    import tagsort_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_valid,
    input  logic [HALF_W-1:0] hw_data,
    output sample_t           smp,
    output logic              tag_err
);

    phase_e           phase;
    logic [IDX_W-1:0] held_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_TAG;
            held_idx <= '0;
            smp      <= '0;
            tag_err  <= 1'b0;
        end else begin
            smp.valid <= 1'b0;
            tag_err   <= 1'b0;
            if (hw_valid) begin
                case (phase)
                    PH_TAG: begin
                        if (tag_ok(hw_data)) begin
                            held_idx <= tag_to_idx(hw_data);
                            phase    <= PH_SAMPLE;
                        end else begin
                            tag_err <= 1'b1;
                        end
                    end
                    PH_SAMPLE: begin
                        smp.valid <= 1'b1;
                        smp.data  <= hw_data;
                        smp.chan  <= held_idx;
                        phase     <= PH_TAG;
                    end
                    default: phase <= PH_TAG;
                endcase
            end
        end
    end

    // R8: output pulses never coincide
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(smp.valid && tag_err));

    // R8: a sample pulse lasts a single cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        smp.valid |=> !smp.valid);

    // R2: delivered index is always a real channel
    a_r2_chan_range: assert property (@(posedge clk) disable iff (rst)
        smp.valid |-> (int'(smp.chan) < CHAN_COUNT));

    // R6: no strobe, no phase movement
    a_r6_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !hw_valid |=> $stable(phase));

    // R3: a rejected tag leaves the framer waiting for a tag
    a_r3_err_in_tag_phase: assert property (@(posedge clk) disable iff (rst)
        tag_err |-> (phase == PH_TAG));

endmodule

// File: rtl/tagsort_counters.sv
module tagsort_counters
    import tagsort_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  sample_t          smp,
    input  logic             tag_err,
    input  logic [IDX_W-1:0] sel_chan,
    output logic [CNT_W-1:0] err_count,
    output logic [CNT_W-1:0] chan_count
);

    logic [CNT_W-1:0] cnt [CHAN_COUNT];

    for (genvar c = 0; c < CHAN_COUNT; c++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[c] <= '0;
            end else if (smp.valid && (smp.chan == IDX_W'(c))) begin
                cnt[c] <= cnt[c] + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_count <= '0;
        end else if (tag_err) begin
            err_count <= err_count + CNT_W'(1);
        end
    end

    always_comb begin
        if (int'(sel_chan) < CHAN_COUNT) begin
            chan_count = cnt[sel_chan];
        end else begin
            chan_count = '0;
        end
    end

    // R4: one step per error pulse
    a_r4_err_step: assert property (@(posedge clk) disable iff (rst)
        tag_err |=> (err_count == $past(err_count) + CNT_W'(1)));

    // R4: otherwise the error count holds
    a_r4_err_hold: assert property (@(posedge clk) disable iff (rst)
        !tag_err |=> $stable(err_count));

    // R5: with no accepted sample and a steady select, the shown count holds
    a_r5_count_hold: assert property (@(posedge clk) disable iff (rst)
        !smp.valid |=> (sel_chan != $past(sel_chan)) || $stable(chan_count));

endmodule

// File: rtl/tagsort_rx.sv
module tagsort_rx
    import tagsort_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_valid,
    input  logic [HALF_W-1:0] hw_data,
    input  logic [IDX_W-1:0]  sel_chan,
    output logic              smp_valid,
    output logic [HALF_W-1:0] smp_data,
    output logic [IDX_W-1:0]  smp_chan,
    output logic              tag_err,
    output logic [CNT_W-1:0]  err_count,
    output logic [CNT_W-1:0]  chan_count
);

    sample_t smp;
    logic    err_pulse;

    tagsort_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .hw_valid (hw_valid),
        .hw_data  (hw_data),
        .smp      (smp),
        .tag_err  (err_pulse)
    );

    tagsort_counters u_counters (
        .clk        (clk),
        .rst        (rst),
        .smp        (smp),
        .tag_err    (err_pulse),
        .sel_chan   (sel_chan),
        .err_count  (err_count),
        .chan_count (chan_count)
    );

    assign smp_valid = smp.valid;
    assign smp_data  = smp.data;
    assign smp_chan  = smp.chan;
    assign tag_err   = err_pulse;

endmodule

// File: tb/tagsort_rx_test.sv
module tagsort_rx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_valid = 1'b0;
    logic [15:0] hw_data = '0;
    logic [4:0]  sel_chan = '0;
    logic        smp_valid;
    logic [15:0] smp_data;
    logic [4:0]  smp_chan;
    logic        tag_err;
    logic [15:0] err_count;
    logic [15:0] chan_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int exp_cnt [24];
    int exp_err = 0;

    always #2 clk = ~clk;

    tagsort_rx uut (
        .clk        (clk),
        .rst        (rst),
        .hw_valid   (hw_valid),
        .hw_data    (hw_data),
        .sel_chan   (sel_chan),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .smp_chan   (smp_chan),
        .tag_err    (tag_err),
        .err_count  (err_count),
        .chan_count (chan_count)
    );

    // {tag, sample, accepted, expected index}
    localparam logic [37:0] VEC [8] = '{
        {16'h0001, 16'hDE33, 1'b1, 5'd0},
        {16'h0018, 16'h1234, 1'b1, 5'd23},
        {16'h0000, 16'h0000, 1'b0, 5'd0},
        {16'h0019, 16'h0000, 1'b0, 5'd0},
        {16'hFFFF, 16'h0000, 1'b0, 5'd0},
        {16'h000C, 16'h7F00, 1'b1, 5'd11},
        {16'h0001, 16'h0042, 1'b1, 5'd0},
        {16'h0017, 16'hFFFF, 1'b1, 5'd22}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_half(input logic [15:0] d);
        @(negedge clk);
        hw_valid = 1'b1;
        hw_data  = d;
        @(negedge clk);
        hw_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    // Sends one word and checks the result visible at the sample strobe's next edge.
    task automatic send_word(input string req, input logic [15:0] tag, input logic [15:0] s,
                             input int ch);
        send_half(tag);
        chk({req, " no output after tag"}, {30'd0, smp_valid, tag_err}, 32'd0);
        send_half(s);
        chk({req, " sample out"}, {smp_valid, smp_chan, smp_data}, {1'b1, 5'(ch), s});
        exp_cnt[ch]++;
    endtask

    task automatic send_bad(input string req, input logic [15:0] tag);
        send_half(tag);
        chk({req, " tag error pulse"}, {30'd0, smp_valid, tag_err}, 32'd1);
        exp_err++;
    endtask

    task automatic check_counts(input string req);
        idle();
        chk({req, " error count"}, {16'd0, err_count}, 32'(exp_err));
        for (int c = 0; c < 24; c++) begin
            sel_chan = 5'(c);
            #1;
            chk({req, " channel count"}, {16'd0, chan_count}, 32'(exp_cnt[c]));
        end
        sel_chan = '0;
    endtask

    initial begin
        for (int c = 0; c < 24; c++) exp_cnt[c] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", {14'd0, smp_valid, tag_err, err_count}, 32'd0);
        chk("R1 reset channel count", {16'd0, chan_count}, 32'd0);
        rst = 1'b0;

        // R2, R3: table of words and rejected tags
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][5]) begin
                send_word("R2", VEC[i][37:22], VEC[i][21:6], int'(VEC[i][4:0]));
                idle();
                chk("R2 single-cycle pulse", {31'd0, smp_valid}, 32'd0);
            end else begin
                send_bad("R3", VEC[i][37:22]);
            end
        end
        // R4, R5: totals after the table
        check_counts("R4 R5");
        sel_chan = 5'd24;
        #1;
        chk("R5 select 24 reads zero", {16'd0, chan_count}, 32'd0);
        sel_chan = 5'd31;
        #1;
        chk("R5 select 31 reads zero", {16'd0, chan_count}, 32'd0);
        sel_chan = '0;

        // R6: gap between the two halves
        send_half(16'h0007);
        for (int k = 0; k < 3; k++) begin
            idle();
            chk("R6 idle gap quiet", {30'd0, smp_valid, tag_err}, 32'd0);
        end
        send_half(16'h4242);
        chk("R6 word across gap", {smp_valid, smp_chan, smp_data}, {1'b1, 5'd6, 16'h4242});
        exp_cnt[6]++;

        // R7: lost tag half, orphan sample rejected, stream re-aligns
        send_bad("R7", 16'h8001);
        send_word("R7", 16'h0010, 16'h0BAD, 15);
        send_bad("R7", 16'h0000);
        send_bad("R7", 16'h0020);
        send_word("R7", 16'h0003, 16'h0003, 2);
        check_counts("R7 R4");

        // R1: reset in the middle of a word discards the held tag
        send_half(16'h0003);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_err = 0;
        for (int c = 0; c < 24; c++) exp_cnt[c] = 0;
        chk("R1 mid-word reset clears errors", {16'd0, err_count}, 32'd0);
        send_word("R1", 16'h0002, 16'h5555, 1);
        check_counts("R1 R5");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule